// File: doc/BRIEF.md
# Unrecoverable Error Collector with Unit Offline Control

This block gathers the fatal-error signals of the units inside a device. Each unit drives one error line. A one-cycle pulse on a line sets a sticky status bit. Software reads the status through a 32-bit register port that addresses dwords by index. It acknowledges an error by writing a one to the status bit. It can also set a mask bit so that an error source no longer counts.

Any status bit that is set while its mask bit is clear raises two level interrupts, one for the host and one for a management controller. The same condition also takes every unit offline: each unit has an online-control bit, and all of those bits are cleared. While such an error stays pending, software cannot bring units back online. Once every pending error has been cleared or masked, software may write the online bits again.

With the default of 48 units, the sources are split into a full 32-bit low word and a 16-bit high word. The upper half of each high word is reserved and reads as zero.

Top module: `fatal_err_agg`

## Requirements
- R1: After a synchronous active-low reset, all status bits and all mask bits are 0, all 48 online bits are 1, and both interrupts are low.
- R2: A one-cycle pulse on `err_evt[i]` sets status bit i at the next clock edge, and the bit stays set until software clears it. Unit i maps to bit i of the low word for i < 32, and to bit i-32 of the high word otherwise.
- R3: A register write to a status word clears every bit written as 1. Bits written as 0 keep their value.
- R4: If an error pulse and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A mask bit of 1 stops its status bit from raising an interrupt and from forcing units offline. The status bit itself still latches.
- R6: `host_irq` and `mgmt_irq` are both high exactly when at least one status bit is set with its mask bit clear. They fall in the cycle after the last such bit is cleared or masked.
- R7: In every clock cycle in which an unmasked error is pending, all online bits are cleared at the next edge.
- R8: Writes to the online words are ignored while an unmasked error is pending. When none is pending, a write loads the written bits into the addressed online word.
- R9: Bits 31:16 of the high status, high mask and high online words read as 0, whatever is written to them.
- R10: The dword map is: low status 40, high status 41, low mask 42, high mask 43, low online 44, high online 45. Reads of any other index return 0, and writes to any other index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt | input | 48 | One error pulse line per unit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Dword index for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| host_irq | output | 1 | Level interrupt toward the host |
| mgmt_irq | output | 1 | Level interrupt toward the management controller |
| unit_online | output | 48 | Online-control bit per unit |

## Verification
The assertions check, on every cycle, that status bits are sticky unless cleared and that a new error wins over a clear. They also check that a pending unmasked error empties the online word one cycle later, that the online bits hold still when nothing writes them and nothing is pending, that the interrupt follows the unmasked status, and that unmapped reads return zero.

Only the bench's scenarios can show the rest: the exact address decode, the write-zero-does-nothing rule, masking that takes effect on an error already pending, refused and then accepted online writes, and the reserved upper bits. The bench shows these by comparing each clock against a behavioural model.

// File: rtl/fea_pkg.sv
// Package: shared sizing helpers for the fatal-error collector.
// Assumes the register data path is one 32-bit dword.
package fea_pkg;
    parameter int WORD_W = 32;

    // Number of unit bits that live in register word idx.
    function automatic int word_bits(input int total, input int idx);
        int rem;
        rem = total - idx * WORD_W;
        return (rem > WORD_W) ? WORD_W : rem;
    endfunction
endpackage

// File: rtl/fea_word.sv
// Module: one status/mask register pair for up to 32 error sources.
// Status bits are sticky and cleared by writing ones; a simultaneous error
// event wins over a clear. pend flags any set status bit whose mask is clear.
// Assumes stat_clr is already qualified by the address decode.
module fea_word #(
    parameter int BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] err_evt,
    input  logic [BITS-1:0] stat_clr,
    input  logic            mask_we,
    input  logic [BITS-1:0] mask_wdata,
    output logic [BITS-1:0] status,
    output logic [BITS-1:0] mask,
    output logic            pend
);
    // Latch error events, drop bits that software cleared (events win).
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~stat_clr) | err_evt;
    end

    // Load the mask word on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    // Any unmasked latched error.
    assign pend = |(status & ~mask);

    // R2: without a clear, no set bit may fall.
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr == '0) |=> ((status & $past(status)) == $past(status)));

    // R4: every bit that saw an event is set afterwards, clear or not.
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt != '0) |=> ((status & $past(err_evt)) == $past(err_evt)));
endmodule

// File: rtl/fea_online.sv
// Module: per-unit online-control bits.
// Any pending unmasked error clears every bit at the next edge. Software
// writes are accepted only when nothing is pending. Reset brings all units
// online. Assumes bit_we is already qualified by the address decode.
module fea_online #(
    parameter int NUM = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pending,
    input  logic [NUM-1:0] bit_we,
    input  logic [NUM-1:0] bit_wdata,
    output logic [NUM-1:0] online
);
    // Force offline on error, otherwise merge software-written bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       online <= '1;
        else if (pending) online <= '0;
        else              online <= (online & ~bit_we) | (bit_wdata & bit_we);
    end

    // R7: a pending unmasked error leaves every unit offline next cycle.
    assert_offline_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> (online == '0));

    // R8: with no write and no pending error, the online bits keep their value.
    assert_online_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && bit_we == '0) |=> $stable(online));
endmodule

// File: rtl/fea_regread.sv
// Module: read multiplexer for the status, mask and online words.
// Words are padded to 32 bits with zeros, so reserved bits read as zero.
// Assumes status, mask and online words sit in consecutive groups from
// BASE_IDX; every other index reads as zero.
module fea_regread #(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 12,
    parameter int BASE_IDX  = 40,
    localparam int PAD_W    = NUM_WORDS * fea_pkg::WORD_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAD_W-1:0]  stat_pad,
    input  logic [PAD_W-1:0]  mask_pad,
    input  logic [PAD_W-1:0]  onl_pad,
    output logic [31:0]       rdata
);
    localparam int W = fea_pkg::WORD_W;

    // Select the addressed dword, zero when the index is unmapped.
    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(addr) == BASE_IDX + w)                 rdata = stat_pad[w*W +: W];
            if (int'(addr) == BASE_IDX + NUM_WORDS + w)     rdata = mask_pad[w*W +: W];
            if (int'(addr) == BASE_IDX + 2 * NUM_WORDS + w) rdata = onl_pad[w*W +: W];
        end
    end
endmodule

// File: rtl/fatal_err_agg.sv
// Module: top of the unrecoverable-error collector.
// Builds one status/mask pair per register word, ORs their pending flags
// into the host and management interrupts, and feeds the same flag to the
// online-control bits. Assumes error inputs are synchronous to clk.
module fatal_err_agg #(
    parameter int NUM_UNITS = 48,
    parameter int ADDR_W    = 12,
    parameter int BASE_IDX  = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] err_evt,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 host_irq,
    output logic                 mgmt_irq,
    output logic [NUM_UNITS-1:0] unit_online
);
    import fea_pkg::*;

    localparam int NUM_WORDS = (NUM_UNITS + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;
    localparam int MAP_END   = BASE_IDX + 3 * NUM_WORDS;

    logic [NUM_UNITS-1:0] stat_all;
    logic [NUM_UNITS-1:0] mask_all;
    logic [NUM_UNITS-1:0] onl_we;
    logic [NUM_UNITS-1:0] onl_wd;
    logic [NUM_WORDS-1:0] pend_w;
    logic                 pending;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        localparam int LO   = g * WORD_W;
        localparam int BITS = word_bits(NUM_UNITS, g);

        logic            hit_stat;
        logic            hit_mask;
        logic            hit_onl;
        logic [BITS-1:0] st;
        logic [BITS-1:0] mk;

        // Decode this word's three register indices.
        assign hit_stat = reg_we && (int'(reg_addr) == BASE_IDX + g);
        assign hit_mask = reg_we && (int'(reg_addr) == BASE_IDX + NUM_WORDS + g);
        assign hit_onl  = reg_we && (int'(reg_addr) == BASE_IDX + 2 * NUM_WORDS + g);

        fea_word #(.BITS(BITS)) u_word (
            .clk        (clk),
            .rst_n      (rst_n),
            .err_evt    (err_evt[LO +: BITS]),
            .stat_clr   (hit_stat ? reg_wdata[BITS-1:0] : '0),
            .mask_we    (hit_mask),
            .mask_wdata (reg_wdata[BITS-1:0]),
            .status     (st),
            .mask       (mk),
            .pend       (pend_w[g])
        );

        assign stat_all[LO +: BITS] = st;
        assign mask_all[LO +: BITS] = mk;
        assign onl_we[LO +: BITS]   = {BITS{hit_onl}};
        assign onl_wd[LO +: BITS]   = reg_wdata[BITS-1:0];
    end

    assign pending  = |pend_w;
    assign host_irq = pending;
    assign mgmt_irq = pending;

    fea_online #(.NUM(NUM_UNITS)) u_online (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .bit_we    (onl_we),
        .bit_wdata (onl_wd),
        .online    (unit_online)
    );

    fea_regread #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W),
        .BASE_IDX  (BASE_IDX)
    ) u_read (
        .addr     (reg_addr),
        .stat_pad (PAD_W'(stat_all)),
        .mask_pad (PAD_W'(mask_all)),
        .onl_pad  (PAD_W'(unit_online)),
        .rdata    (reg_rdata)
    );

    // R6: the interrupt level follows the unmasked status, seen from the words' outputs.
    assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == (|(stat_all & ~mask_all)));

    // R10: indices outside the mapped window read as zero.
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) < BASE_IDX || int'(reg_addr) >= MAP_END) |-> (reg_rdata == '0));

    // R5: a fully masked status never raises the interrupt.
    assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_all & ~mask_all) == '0) |-> !mgmt_irq);
endmodule

// File: tb/fatal_err_agg_test.sv
// Bench: directed scenarios plus random traffic, checked against a
// behavioural model on every falling clock edge.
module fatal_err_agg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] err_evt = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq, mgmt_irq;
    logic [47:0] unit_online;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // Model state
    logic [47:0] m_stat, m_mask, m_onl;

    fatal_err_agg uut (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_irq(host_irq), .mgmt_irq(mgmt_irq), .unit_online(unit_online)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'd40:  return m_stat[31:0];
            12'd41:  return {16'h0, m_stat[47:32]};
            12'd42:  return m_mask[31:0];
            12'd43:  return {16'h0, m_mask[47:32]};
            12'd44:  return m_onl[31:0];
            12'd45:  return {16'h0, m_onl[47:32]};
            default: return 32'h0;
        endcase
    endfunction

    // Behavioural model update
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0; m_mask = '0; m_onl = '1;
        end else begin
            logic        was_pend;
            logic [47:0] clr;
            was_pend = |(m_stat & ~m_mask);
            clr = '0;
            if (reg_we && reg_addr == 12'd40) clr[31:0]  = reg_wdata;
            if (reg_we && reg_addr == 12'd41) clr[47:32] = reg_wdata[15:0];
            m_stat = (m_stat & ~clr) | err_evt;
            if (reg_we && reg_addr == 12'd42) m_mask[31:0]  = reg_wdata;
            if (reg_we && reg_addr == 12'd43) m_mask[47:32] = reg_wdata[15:0];
            if (was_pend) m_onl = '0;
            else begin
                if (reg_we && reg_addr == 12'd44) m_onl[31:0]  = reg_wdata;
                if (reg_we && reg_addr == 12'd45) m_onl[47:32] = reg_wdata[15:0];
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_irq;
            exp_irq = |(m_stat & ~m_mask);
            checks++;
            if (host_irq !== exp_irq || mgmt_irq !== exp_irq) begin
                errors++;
                $display("FAIL %s/R6 irq host=%0b mgmt=%0b expected %0b", tag, host_irq, mgmt_irq, exp_irq);
            end
            checks++;
            if (unit_online !== m_onl) begin
                errors++;
                $display("FAIL %s/R7 online %h expected %h", tag, unit_online, m_onl);
            end
            checks++;
            if (reg_rdata !== m_read(reg_addr)) begin
                errors++;
                $display("FAIL %s/R10 rdata@%0d %h expected %h", tag, reg_addr, reg_rdata, m_read(reg_addr));
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            reg_we = 1'b0; err_evt = '0;
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; err_evt = '0;
        @(negedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [47:0] e);
        @(negedge clk); #1;
        err_evt = e; reg_we = 1'b0;
        @(negedge clk); #1;
        err_evt = '0;
    endtask

    // Directed read with a literal expected value
    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); #1;
        reg_we = 1'b0; err_evt = '0; reg_addr = a;
        @(negedge clk);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read@%0d %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic exp, input string req);
        @(negedge clk);
        checks++;
        if (host_irq !== exp || mgmt_irq !== exp) begin
            errors++;
            $display("FAIL %s irq %0b/%0b expected %0b", req, host_irq, mgmt_irq, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired, actual running expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;

        tag = "R1";
        rd_chk(12'd40, 32'h0, "R1");
        rd_chk(12'd43, 32'h0, "R1");
        rd_chk(12'd44, 32'hFFFF_FFFF, "R1");
        rd_chk(12'd45, 32'h0000_FFFF, "R1");
        irq_chk(1'b0, "R1");

        tag = "R2";
        pulse(48'h8);
        idle(3);
        rd_chk(12'd40, 32'h8, "R2");
        irq_chk(1'b1, "R6");
        rd_chk(12'd44, 32'h0, "R7");

        tag = "R8";
        wr(12'd44, 32'hFFFF_FFFF);
        rd_chk(12'd44, 32'h0, "R8");

        tag = "R3";
        wr(12'd40, 32'h0);
        rd_chk(12'd40, 32'h8, "R3");
        wr(12'd40, 32'h8);
        rd_chk(12'd40, 32'h0, "R3");
        irq_chk(1'b0, "R6");

        tag = "R8";
        wr(12'd44, 32'hA5A5_0F0F);
        rd_chk(12'd44, 32'hA5A5_0F0F, "R8");
        wr(12'd45, 32'hFFFF_FFFF);
        rd_chk(12'd45, 32'h0000_FFFF, "R9");

        tag = "R5";
        wr(12'd43, 32'h0000_0100);
        pulse(48'h0100_0000_0000);
        idle(2);
        rd_chk(12'd41, 32'h0000_0100, "R5");
        irq_chk(1'b0, "R5");
        rd_chk(12'd44, 32'hA5A5_0F0F, "R5");
        rd_chk(12'd43, 32'h0000_0100, "R9");
        wr(12'd41, 32'h100);

        tag = "R4";
        @(negedge clk); #1;
        reg_we = 1'b1; reg_addr = 12'd40; reg_wdata = 32'h20; err_evt = 48'h20;
        idle(1);
        rd_chk(12'd40, 32'h20, "R4");
        wr(12'd42, 32'h20);
        irq_chk(1'b0, "R5");
        wr(12'd40, 32'h20);
        wr(12'd42, 32'h0);

        tag = "R10";
        wr(12'd39, 32'hFFFF_FFFF);
        wr(12'd46, 32'hFFFF_FFFF);
        rd_chk(12'd39, 32'h0, "R10");
        rd_chk(12'd46, 32'h0, "R10");
        rd_chk(12'd40, 32'h0, "R10");
        rd_chk(12'd42, 32'h0, "R10");

        tag = "R2R3R5R8";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk); #1;
            err_evt   = (($urandom % 10) == 0) ? (48'h1 << ($urandom % 48)) : 48'h0;
            reg_we    = ($urandom % 2) == 1;
            reg_addr  = 12'(38 + ($urandom % 10));
            reg_wdata = (($urandom % 3) == 0) ? 32'hFFFF_FFFF : $urandom;
        end
        idle(2);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule